// File: doc/BRIEF.md
# Prioritised Interrupt Acknowledge Sequencer

This block decides, at each instruction boundary, whether the processor takes an interrupt and what kind it is. There are two classes. A software trap is raised when the decoder sees the all-zero opcode. It cannot be masked and is taken at the boundary where it appears. Maskable requests come from an external pin and from a set of on-chip peripherals. Each source keeps its own pending bit. A maskable request is taken only when the global enable is set and no service routine of either class is running.

When the block accepts an interrupt, it emits a one-cycle take pulse. The pulse comes with a vector-kind select and a fixed entry address. Accepting a maskable interrupt clears the global enable and marks a routine as in service. A return strobe clears the in-service mark and sets the global enable again. A trap sets a separate in-trap flag, which only a dedicated pending-reset strobe clears. While code runs from boot memory, hardware interrupts are held off and the global enable is left as it is. Pending bits are kept during that time, so an enabled request fires once execution leaves boot memory. A second request from a source that is already pending adds nothing and is lost.

Top module: `irq_ack_seq`

## Requirements
- R1: After reset, take_o is 0, vec_sel_o is 2'b00, vec_addr_o is 0, and gie_o, in_isr_o, in_trap_o and every bit of pend_o are 0.
- R2: When insn_done_i and trap_i are both 1 at a clock edge, the next cycle shows take_o=1, vec_sel_o=2'b10 and vec_addr_o=TRAP_VEC, and in_trap_o becomes 1. This happens whatever the values of gie_o, boot_i, in_isr_o and in_trap_o.
- R3: A maskable interrupt is accepted at an edge where all of the following hold: insn_done_i=1, trap_i=0, gie_o=1, in_isr_o=0, in_trap_o=0, boot_i=0, and at least one pending bit whose enable is set. The next cycle then shows take_o=1, vec_sel_o=2'b01, vec_addr_o=MASK_VEC, gie_o=0 and in_isr_o=1.
- R4: When a trap and an acceptable maskable request meet at the same boundary, the trap is taken and the maskable pending bit stays set. vec_sel_o is 2'b00 whenever take_o is 0.
- R5: take_o is 1 only in the cycle after an edge with insn_done_i=1. At most one interrupt is taken per boundary.
- R6: reti_i clears in_isr_o and sets gie_o, and leaves in_trap_o unchanged. rpnd_i clears in_trap_o unless a trap is accepted at the same edge.
- R7: pend_o[0] is the external pin's pending bit. It is set by a rising edge of ext_pin_i when ext_pol_i=0, or by a falling edge when ext_pol_i=1. It is cleared by ext_clr_i, but a new edge at the same edge wins. It counts as a request only while ext_en_i=1.
- R8: pend_o[k+1] is peripheral k's pending bit. It is set by per_req_i[k] and cleared by per_clr_i[k], with a set winning over a clear at the same edge. It counts as a request only while per_en_i[k]=1.
- R9: While boot_i=1, no maskable interrupt is taken and gie_o changes only by reti_i or gie_wr_i. Pending bits are kept and fire after boot_i falls. A repeated request from an already-pending source is lost.
- R10: gie_wr_i loads gie_wdata_i into gie_o. When more than one update falls on the same edge, maskable acceptance (clear) wins over reti_i (set), which wins over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_done_i | input | 1 | Instruction boundary marker |
| trap_i | input | 1 | All-zero opcode decoded at this boundary |
| reti_i | input | 1 | Return-from-interrupt strobe |
| rpnd_i | input | 1 | Trap pending-reset strobe |
| gie_wr_i | input | 1 | Software write of the global enable |
| gie_wdata_i | input | 1 | Value for that write |
| boot_i | input | 1 | Execution is in boot memory |
| ext_pin_i | input | 1 | External interrupt pin |
| ext_pol_i | input | 1 | Pin edge select, 0 rising, 1 falling |
| ext_en_i | input | 1 | Pin interrupt enable |
| ext_clr_i | input | 1 | Clear pin pending bit |
| per_req_i | input | NUM_PER | Peripheral request pulses |
| per_en_i | input | NUM_PER | Peripheral enables |
| per_clr_i | input | NUM_PER | Peripheral pending clears |
| take_o | output | 1 | Interrupt taken (one-cycle pulse) |
| vec_sel_o | output | 2 | 01 maskable, 10 trap, 00 none |
| vec_addr_o | output | ADDR_W | Entry address while take_o is 1, else 0 |
| gie_o | output | 1 | Global enable state |
| in_isr_o | output | 1 | Maskable routine in service |
| in_trap_o | output | 1 | Trap routine in progress |
| pend_o | output | NUM_PER+1 | Pending bits, bit 0 is the pin |

## Verification
The bench builds the block with NUM_PER=3, so there are four maskable sources, and with TRAP_VEC=0x0FE distinct from MASK_VEC=0x0FF. A wrong vector kind therefore also shows up as a wrong address. Four sources are few enough that random pulses often leave several bits pending at once. Short random boot phases land on top of a pending request often enough to reach both the held-off case and the lost-repeat case. Random return and pending-reset strobes bring trap-inside-maskable nesting and coinciding updates to the enable within reach.

// File: rtl/irq_ack_pkg.sv
// Package: shared types for the interrupt acknowledge sequencer.
// Assumes: vector-kind codes are decoded by the fetch unit downstream.
package irq_ack_pkg;

    // Kind of vector selected on an accepted interrupt.
    typedef enum logic [1:0] {
        VSEL_NONE = 2'b00,
        VSEL_MASK = 2'b01,
        VSEL_TRAP = 2'b10
    } vsel_e;

    // Decision made for one instruction boundary.
    typedef struct packed {
        logic trap_take;
        logic mask_take;
    } take_t;

endpackage

// File: rtl/irq_edge_pend.sv
// Module: irq_edge_pend
// Captures a selected edge of the external interrupt pin into a pending bit.
// Assumes: the pin is already synchronous to clk; software clears the bit.
module irq_edge_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic pol_i,
    input  logic clr_i,
    output logic pend_o
);

    logic pin_q;
    logic edge_hit;

    // Remember the previous pin level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_i;
    end

    // Select rising (pol 0) or falling (pol 1) edge.
    always_comb begin
        if (pol_i) edge_hit = pin_q & ~pin_i;
        else       edge_hit = ~pin_q & pin_i;
    end

    // Pending bit: a new edge wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_o <= 1'b0;
        else if (edge_hit) pend_o <= 1'b1;
        else if (clr_i)    pend_o <= 1'b0;
    end

endmodule

// File: rtl/irq_pend_bank.sv
// Module: irq_pend_bank
// One pending bit per peripheral source, set by request pulses.
// Assumes: a repeated request on a set bit is absorbed, not counted.
module irq_pend_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    for (genvar k = 0; k < N; k++) begin : g_src
        // Per-source pending bit: request wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        pend_o[k] <= 1'b0;
            else if (req_i[k]) pend_o[k] <= 1'b1;
            else if (clr_i[k]) pend_o[k] <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
// Module: irq_arbiter
// Decides at an instruction boundary whether a trap or a maskable
// interrupt is accepted. Purely combinational.
// Assumes: trap_i is only meaningful together with done_i.
module irq_arbiter
    import irq_ack_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic [NSRC-1:0] pend_i,
    input  logic [NSRC-1:0] en_i,
    input  logic            done_i,
    input  logic            trap_i,
    input  logic            gie_i,
    input  logic            isr_i,
    input  logic            intrap_i,
    input  logic            boot_i,
    output take_t           take_o
);

    logic any_req;
    logic mask_ok;

    // Any enabled pending source, and whether a maskable one may enter.
    always_comb begin
        any_req = |(pend_i & en_i);
        mask_ok = gie_i & ~isr_i & ~intrap_i & ~boot_i;
    end

    // Trap ranks first; at most one acceptance per boundary.
    always_comb begin
        take_o.trap_take = done_i & trap_i;
        take_o.mask_take = done_i & ~trap_i & mask_ok & any_req;
    end

endmodule

// File: rtl/irq_state.sv
// Module: irq_state
// Holds the global enable, in-service and in-trap flags and registers
// the acknowledge outputs.
// Assumes: arbiter decisions are mutually exclusive.
module irq_state
    import irq_ack_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] MASK_VEC = 12'h0FF,
    parameter logic [ADDR_W-1:0] TRAP_VEC = 12'h0FE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  take_t             take_i,
    input  logic              reti_i,
    input  logic              rpnd_i,
    input  logic              gie_wr_i,
    input  logic              gie_wdata_i,
    output logic              take_o,
    output vsel_e             vsel_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              gie_o,
    output logic              isr_o,
    output logic              intrap_o
);

    // Acknowledge pulse with the kind and entry address of the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o <= 1'b0;
            vsel_o <= VSEL_NONE;
            addr_o <= '0;
        end else if (take_i.trap_take) begin
            take_o <= 1'b1;
            vsel_o <= VSEL_TRAP;
            addr_o <= TRAP_VEC;
        end else if (take_i.mask_take) begin
            take_o <= 1'b1;
            vsel_o <= VSEL_MASK;
            addr_o <= MASK_VEC;
        end else begin
            take_o <= 1'b0;
            vsel_o <= VSEL_NONE;
            addr_o <= '0;
        end
    end

    // Global enable: acceptance clears, return sets, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n)                 gie_o <= 1'b0;
        else if (take_i.mask_take)  gie_o <= 1'b0;
        else if (reti_i)            gie_o <= 1'b1;
        else if (gie_wr_i)          gie_o <= gie_wdata_i;
    end

    // Maskable routine in service: set on acceptance, cleared on return.
    always_ff @(posedge clk) begin
        if (!rst_n)                isr_o <= 1'b0;
        else if (take_i.mask_take) isr_o <= 1'b1;
        else if (reti_i)           isr_o <= 1'b0;
    end

    // Trap in progress: set on trap, cleared only by pending reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                intrap_o <= 1'b0;
        else if (take_i.trap_take) intrap_o <= 1'b1;
        else if (rpnd_i)           intrap_o <= 1'b0;
    end

endmodule

// File: rtl/irq_ack_seq.sv
// Module: irq_ack_seq (top)
// Interrupt acknowledge sequencer: pending capture, boundary arbitration
// between software trap and maskable sources, and enable/nesting state.
// Assumes: all inputs synchronous to clk; trap_i accompanies insn_done_i.
module irq_ack_seq
    import irq_ack_pkg::*;
#(
    parameter int                NUM_PER  = 3,
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] MASK_VEC = 12'h0FF,
    parameter logic [ADDR_W-1:0] TRAP_VEC = 12'h0FE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               insn_done_i,
    input  logic               trap_i,
    input  logic               reti_i,
    input  logic               rpnd_i,
    input  logic               gie_wr_i,
    input  logic               gie_wdata_i,
    input  logic               boot_i,
    input  logic               ext_pin_i,
    input  logic               ext_pol_i,
    input  logic               ext_en_i,
    input  logic               ext_clr_i,
    input  logic [NUM_PER-1:0] per_req_i,
    input  logic [NUM_PER-1:0] per_en_i,
    input  logic [NUM_PER-1:0] per_clr_i,
    output logic               take_o,
    output logic [1:0]         vec_sel_o,
    output logic [ADDR_W-1:0]  vec_addr_o,
    output logic               gie_o,
    output logic               in_isr_o,
    output logic               in_trap_o,
    output logic [NUM_PER:0]   pend_o
);

    localparam int NUM_SRC = NUM_PER + 1;

    logic               ext_pend;
    logic [NUM_PER-1:0] per_pend;
    logic [NUM_SRC-1:0] src_en;
    take_t              decide;
    vsel_e              vsel;

    // Gather pending bits and enables; pin is source 0.
    always_comb begin
        pend_o    = {per_pend, ext_pend};
        src_en    = {per_en_i, ext_en_i};
        vec_sel_o = vsel;
    end

    irq_edge_pend u_ext (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin_i),
        .pol_i  (ext_pol_i),
        .clr_i  (ext_clr_i),
        .pend_o (ext_pend)
    );

    irq_pend_bank #(.N(NUM_PER)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (per_req_i),
        .clr_i  (per_clr_i),
        .pend_o (per_pend)
    );

    irq_arbiter #(.NSRC(NUM_SRC)) u_arb (
        .pend_i   (pend_o),
        .en_i     (src_en),
        .done_i   (insn_done_i),
        .trap_i   (trap_i),
        .gie_i    (gie_o),
        .isr_i    (in_isr_o),
        .intrap_i (in_trap_o),
        .boot_i   (boot_i),
        .take_o   (decide)
    );

    irq_state #(
        .ADDR_W   (ADDR_W),
        .MASK_VEC (MASK_VEC),
        .TRAP_VEC (TRAP_VEC)
    ) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (decide),
        .reti_i      (reti_i),
        .rpnd_i      (rpnd_i),
        .gie_wr_i    (gie_wr_i),
        .gie_wdata_i (gie_wdata_i),
        .take_o      (take_o),
        .vsel_o      (vsel),
        .addr_o      (vec_addr_o),
        .gie_o       (gie_o),
        .isr_o       (in_isr_o),
        .intrap_o    (in_trap_o)
    );

endmodule

// File: rtl/irq_ack_seq_chk.sv
// Module: irq_ack_seq_chk
// Assertion checker for irq_ack_seq, attached through bind.
// Assumes: observes top-level ports only.
module irq_ack_seq_chk #(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] MASK_VEC = 12'h0FF,
    parameter logic [ADDR_W-1:0] TRAP_VEC = 12'h0FE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_done_i,
    input logic              trap_i,
    input logic              reti_i,
    input logic              rpnd_i,
    input logic              gie_wr_i,
    input logic              boot_i,
    input logic              take_o,
    input logic [1:0]        vec_sel_o,
    input logic [ADDR_W-1:0] vec_addr_o,
    input logic              gie_o,
    input logic              in_isr_o,
    input logic              in_trap_o
);

    p_trap_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done_i && trap_i |=> take_o && vec_sel_o == 2'b10
                                  && vec_addr_o == TRAP_VEC && in_trap_o);

    p_mask_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o && vec_sel_o == 2'b01 |-> !gie_o && in_isr_o && vec_addr_o == MASK_VEC);

    p_sel_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vec_sel_o) && (take_o == (vec_sel_o != 2'b00)));

    p_boundary_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_done_i |=> !take_o);

    p_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i && !insn_done_i |=> gie_o && !in_isr_o);

    p_trap_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rpnd_i && !(insn_done_i && trap_i) |=> !in_trap_o);

    p_boot_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done_i && boot_i && !trap_i |=> !take_o);

    p_boot_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
        boot_i && !reti_i && !gie_wr_i |=> $stable(gie_o));

endmodule

bind irq_ack_seq irq_ack_seq_chk #(
    .ADDR_W   (ADDR_W),
    .MASK_VEC (MASK_VEC),
    .TRAP_VEC (TRAP_VEC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn_done_i (insn_done_i),
    .trap_i      (trap_i),
    .reti_i      (reti_i),
    .rpnd_i      (rpnd_i),
    .gie_wr_i    (gie_wr_i),
    .boot_i      (boot_i),
    .take_o      (take_o),
    .vec_sel_o   (vec_sel_o),
    .vec_addr_o  (vec_addr_o),
    .gie_o       (gie_o),
    .in_isr_o    (in_isr_o),
    .in_trap_o   (in_trap_o)
);

// File: tb/irq_ack_seq_test.sv
module irq_ack_seq_test;

    localparam int             NP = 3;
    localparam int             NS = NP + 1;
    localparam int             AW = 12;
    localparam logic [AW-1:0]  MV = 12'h0FF;
    localparam logic [AW-1:0]  TV = 12'h0FE;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, insn_done, trap, reti, rpnd, gie_wr, gie_wdata, boot;
    logic ext_pin, ext_pol, ext_en, ext_clr;
    logic [NP-1:0] per_req, per_en, per_clr;
    logic take;
    logic [1:0] vsel;
    logic [AW-1:0] vaddr;
    logic gie, isr, intrap;
    logic [NS-1:0] pend;

    irq_ack_seq #(.NUM_PER(NP), .ADDR_W(AW), .MASK_VEC(MV), .TRAP_VEC(TV)) uut (
        .clk(clk), .rst_n(rst_n), .insn_done_i(insn_done), .trap_i(trap),
        .reti_i(reti), .rpnd_i(rpnd), .gie_wr_i(gie_wr), .gie_wdata_i(gie_wdata),
        .boot_i(boot), .ext_pin_i(ext_pin), .ext_pol_i(ext_pol), .ext_en_i(ext_en),
        .ext_clr_i(ext_clr), .per_req_i(per_req), .per_en_i(per_en),
        .per_clr_i(per_clr), .take_o(take), .vec_sel_o(vsel), .vec_addr_o(vaddr),
        .gie_o(gie), .in_isr_o(isr), .in_trap_o(intrap), .pend_o(pend)
    );

    // Reference model state
    logic m_take, m_gie, m_isr, m_trap, m_extq;
    logic [1:0] m_vsel;
    logic [AW-1:0] m_addr;
    logic [NS-1:0] m_pend;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit finished = 0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            wrap_up();
        end
    end

    function automatic logic edge_of(logic pol, logic prev, logic now);
        return pol ? (prev & ~now) : (~prev & now);
    endfunction

    // Advance the model by one edge from the inputs now driven.
    task automatic model_step();
        logic e, anyp, tt, mt;
        logic [NS-1:0] np;
        e = edge_of(ext_pol, m_extq, ext_pin);
        anyp = |(m_pend & {per_en, ext_en});
        tt = insn_done & trap;
        mt = insn_done & ~trap & m_gie & ~m_isr & ~m_trap & ~boot & anyp;
        np[0] = e | (m_pend[0] & ~ext_clr);
        for (int k = 0; k < NP; k++) np[k+1] = per_req[k] | (m_pend[k+1] & ~per_clr[k]);
        m_extq = ext_pin;
        m_pend = np;
        m_take = tt | mt;
        m_vsel = tt ? 2'b10 : (mt ? 2'b01 : 2'b00);
        m_addr = tt ? TV : (mt ? MV : '0);
        m_gie  = mt ? 1'b0 : (reti ? 1'b1 : (gie_wr ? gie_wdata : m_gie));
        m_isr  = mt ? 1'b1 : (reti ? 1'b0 : m_isr);
        m_trap = tt ? 1'b1 : (rpnd ? 1'b0 : m_trap);
    endtask

    task automatic compare_all();
        chk("R5", "take", take, m_take);
        chk("R4", "vec_sel", vsel, m_vsel);
        chk(m_vsel == 2'b10 ? "R2" : "R3", "vec_addr", vaddr, m_addr);
        chk("R10", "gie", gie, m_gie);
        chk("R6", "in_isr", isr, m_isr);
        chk("R6", "in_trap", intrap, m_trap);
        chk("R7", "pend_pin", pend[0], m_pend[0]);
        chk("R8", "pend_per", pend[NS-1:1], m_pend[NS-1:1]);
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic strobes_off();
        insn_done = 0; trap = 0; reti = 0; rpnd = 0; gie_wr = 0; gie_wdata = 0;
        ext_clr = 0; per_req = '0; per_clr = '0;
    endtask

    initial begin
        logic [31:0] seed;
        int takes;
        seed = $urandom(32'd24681);
        rst_n = 0; strobes_off(); boot = 0;
        ext_pin = 0; ext_pol = 0; ext_en = 0; per_en = '0;
        m_take = 0; m_vsel = 0; m_addr = 0; m_gie = 0; m_isr = 0; m_trap = 0;
        m_extq = 0; m_pend = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "take", take, 0);
        chk("R1", "vec_sel", vsel, 0);
        chk("R1", "vec_addr", vaddr, 0);
        chk("R1", "gie", gie, 0);
        chk("R1", "in_isr", isr, 0);
        chk("R1", "in_trap", intrap, 0);
        chk("R1", "pend", pend, 0);
        rst_n = 1;

        // R10 software write of the enable
        gie_wr = 1; gie_wdata = 1; cycle(); strobes_off();
        chk("R10", "gie after write", gie, 1);

        // R8 peripheral 1 request, then R3 acceptance
        per_en = '1; per_req[1] = 1; cycle(); strobes_off();
        chk("R8", "pend bit 2", pend[2], 1);
        // R5 no boundary, no take
        repeat (3) begin cycle(); chk("R5", "take without boundary", take, 0); end
        insn_done = 1; cycle(); strobes_off();
        chk("R3", "take", take, 1);
        chk("R3", "vec_sel", vsel, 2'b01);
        chk("R3", "vec_addr", vaddr, MV);
        chk("R3", "gie cleared", gie, 0);
        chk("R3", "in_isr", isr, 1);

        // R2 trap preempts the maskable routine
        insn_done = 1; trap = 1; cycle(); strobes_off();
        chk("R2", "take", take, 1);
        chk("R2", "vec_sel", vsel, 2'b10);
        chk("R2", "vec_addr", vaddr, TV);
        chk("R2", "in_trap", intrap, 1);
        chk("R2", "in_isr kept", isr, 1);

        // R6 ordinary return leaves trap flag, pending reset clears it
        reti = 1; cycle(); strobes_off();
        chk("R6", "in_trap after reti", intrap, 1);
        chk("R6", "gie after reti", gie, 1);
        rpnd = 1; cycle(); strobes_off();
        chk("R6", "in_trap after rpnd", intrap, 0);
        per_clr[1] = 1; cycle(); strobes_off();

        // R7 falling-edge capture on the pin
        ext_pol = 1; ext_en = 1; ext_pin = 1; cycle();
        chk("R7", "no capture on rise", pend[0], 0);
        ext_pin = 0; cycle();
        chk("R7", "capture on fall", pend[0], 1);

        // R4 trap and maskable at same boundary
        insn_done = 1; trap = 1; cycle(); strobes_off();
        chk("R4", "trap wins", vsel, 2'b10);
        chk("R4", "pin still pending", pend[0], 1);
        rpnd = 1; cycle(); strobes_off();
        insn_done = 1; cycle(); strobes_off();
        chk("R3", "maskable after trap", vsel, 2'b01);
        reti = 1; ext_clr = 1; cycle(); strobes_off();

        // R9 boot execution holds off interrupts, repeats are lost
        boot = 1;
        per_req[0] = 1; cycle(); strobes_off();
        cycle();
        per_req[0] = 1; cycle(); strobes_off();
        takes = 0;
        repeat (4) begin insn_done = 1; cycle(); strobes_off(); takes += take; end
        chk("R9", "takes during boot", takes, 0);
        chk("R9", "gie kept during boot", gie, 1);
        chk("R9", "pending kept", pend[1], 1);
        boot = 0; insn_done = 1; cycle(); strobes_off();
        chk("R9", "fires after boot", take, 1);
        reti = 1; per_clr[0] = 1; cycle(); strobes_off();
        insn_done = 1; cycle(); strobes_off();
        chk("R9", "repeat lost", take, 0);

        // R10 acceptance clear beats reti and write in the same edge
        per_req[2] = 1; cycle(); strobes_off();
        insn_done = 1; reti = 1; gie_wr = 1; gie_wdata = 1; cycle(); strobes_off();
        chk("R10", "clear wins", gie, 0);
        reti = 1; per_clr[2] = 1; cycle(); strobes_off();

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            insn_done = $urandom % 2;
            trap      = ($urandom % 20) == 0;
            reti      = ($urandom % 10) == 0;
            rpnd      = ($urandom % 10) == 0;
            gie_wr    = ($urandom % 6) == 0;
            gie_wdata = ($urandom % 4) != 0;
            if (($urandom % 40) == 0) boot = ~boot;
            if (($urandom % 3) == 0) ext_pin = ~ext_pin;
            if (($urandom % 50) == 0) ext_pol = ~ext_pol;
            ext_en    = ($urandom % 8) != 0;
            ext_clr   = ($urandom % 6) == 0;
            per_req   = (($urandom % 4) == 0) ? NP'($urandom) : '0;
            per_en    = (($urandom % 4) != 0) ? '1 : NP'($urandom);
            per_clr   = (($urandom % 5) == 0) ? NP'($urandom) : '0;
            cycle();
        end
        strobes_off();
        cycle();
        wrap_up();
    end

endmodule